// File: doc/BRIEF.md
# Power-of-Two Debounce Filter

This block cleans up slow mechanical or noisy pin inputs before they reach the rest of the chip. Every pin has its own filter. The filter holds its output until the synchronised input has stayed at a new level for a settle time of 2^code milliseconds. A 3-bit code per pin picks that time, from 1 ms up to 128 ms. All pins share one prescaler, which divides the system clock down to a one-millisecond strobe.

Each pin also has an enable. With the enable low, the filter is bypassed: the output follows the synchronised input after a fixed register latency. A pin's enable and code are static configuration, driven by whatever register logic sits beside the block. A change to either takes effect cleanly. A new code restarts the settle count, and dropping the enable delivers the current input at once.

Top module: `pow2_debounce`

## Requirements
- R1: After reset every filtered output is 0, and it stays 0 while the raw inputs stay 0.
- R2: With a pin's enable low, its output follows the raw input. A change driven just after one rising edge appears on the output after the third rising edge that follows, and no earlier (SYNC_STAGES + 1 edges).
- R3: With the enable high, one millisecond is CLK_HZ/1000 clock cycles. A rate code c (0..7) sets a settle time of N = 2^c ms. After a raw input change, the output takes the new level no sooner than 3 + (N-1)·CLK_HZ/1000 edges and no later than 2 + N·CLK_HZ/1000 edges.
- R4: With the enable high, a raw level that returns to the output's value within (N-1) ms never reaches the output.
- R5: A change of a pin's rate code restarts that pin's settle count. The output then changes between 2 + (N-1)·CLK_HZ/1000 and 1 + N·CLK_HZ/1000 edges after the code change, where N is the new period.
- R6: Pins are independent. Activity on one pin's raw input, enable or code never alters another pin's output.
- R7: Clearing the enable while a change is still settling puts the synchronised input on the output at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rawIn | input | NUM_PINS | Unsynchronised pin levels |
| dbEnable | input | NUM_PINS | Per-pin filter enable; low selects the bypass path |
| rateCode | input | NUM_PINS*3 | Per-pin settle code; pin p uses bits [3p+2:3p]; period is 2^code ms |
| filtOut | output | NUM_PINS | Debounced pin levels |

## Verification
The bench builds the block with CLK_HZ = 8000, which makes one millisecond eight clock cycles. At that rate even the 128 ms setting settles in about a thousand cycles, so codes 0, 1, 3 and 7 are all timed against their exact early and late bounds. Two pins and two synchroniser stages are enough to observe bypass latency, disable-during-settle and cross-pin isolation. Because the prescaler period is short, a code change can be placed partway through a settle and the restart told apart from a continued count.

// File: rtl/debounce_pkg.sv
package debounce_pkg;

  // Strobes broadcast from the shared control to every pin datapath.
  typedef struct packed {
    logic msTick;   // one-cycle pulse once per millisecond
  } dbStrobes_t;

endpackage

// File: rtl/debounce_ctrl.sv
module debounce_ctrl
  import debounce_pkg::*;
#(
  parameter int TICK_DIV = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  output dbStrobes_t strobes
);

  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] preCount;
  logic             tickQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCount <= '0;
      tickQ    <= 1'b0;
    end else if (preCount == PRE_LAST) begin
      preCount <= '0;
      tickQ    <= 1'b1;
    end else begin
      preCount <= preCount + 1'b1;
      tickQ    <= 1'b0;
    end
  end

  assign strobes.msTick = tickQ;

  generate
    if (TICK_DIV > 1) begin : gTickCheck
      // R3: the millisecond strobe is a single-cycle pulse
      a_r3_tick_single: assert property (@(posedge clk) disable iff (!rstN)
        strobes.msTick |=> !strobes.msTick);
    end
  endgenerate

endmodule

// File: rtl/debounce_datapath.sv
module debounce_datapath
  import debounce_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MAX_CODE    = 7,
  parameter int CODE_W      = 3,
  parameter int CNT_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dbStrobes_t        strobes,
  input  logic              rawIn,
  input  logic              enable,
  input  logic [CODE_W-1:0] rateCode,
  output logic              filtOut
);

  logic              syncIn;
  logic [CODE_W-1:0] codeEff;
  logic [CODE_W-1:0] codeSeen;
  logic              codeChanged;
  logic [CNT_W-1:0]  target;
  logic [CNT_W-1:0]  lastCount;
  logic [CNT_W-1:0]  stableCnt;
  logic              outQ;

  // Synchroniser chain; the variant depends on the stage count.
  generate
    if (SYNC_STAGES <= 1) begin : gSyncOne
      logic syncReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg <= 1'b0;
        else       syncReg <= rawIn;
      end
      assign syncIn = syncReg;
    end else begin : gSyncMany
      logic [SYNC_STAGES-1:0] syncChain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], rawIn};
      end
      assign syncIn = syncChain[SYNC_STAGES-1];
    end
  endgenerate

  // Codes above the supported range are clamped to the longest period.
  always_comb begin
    if (32'(rateCode) > MAX_CODE) codeEff = CODE_W'(MAX_CODE);
    else                          codeEff = rateCode;
  end

  assign codeChanged = (codeEff != codeSeen);
  assign target      = CNT_W'(1) << codeEff;
  assign lastCount   = target - 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeSeen  <= '0;
      stableCnt <= '0;
      outQ      <= 1'b0;
    end else begin
      codeSeen <= codeEff;
      if (!enable) begin
        outQ      <= syncIn;
        stableCnt <= '0;
      end else if ((syncIn == outQ) || codeChanged) begin
        stableCnt <= '0;
      end else if (strobes.msTick) begin
        if (stableCnt >= lastCount) begin
          outQ      <= syncIn;
          stableCnt <= '0;
        end else begin
          stableCnt <= stableCnt + 1'b1;
        end
      end
    end
  end

  assign filtOut = outQ;

  // R3: with the filter active, the output moves only on a millisecond strobe
  a_r3_change_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    ($past(enable) && (filtOut != $past(filtOut))) |-> $past(strobes.msTick));

  // R3: the settle count stays below the selected period
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !codeChanged) |-> (stableCnt < target));

  // R5: a code change never lets the output flip on the same edge
  a_r5_restart_holds: assert property (@(posedge clk) disable iff (!rstN)
    (enable && codeChanged) |=> $stable(filtOut));

  // R2: in bypass the output takes the synchronised level one edge later
  a_r2_bypass_follow: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (filtOut == $past(syncIn)));

endmodule

// File: rtl/pow2_debounce.sv
module pow2_debounce
  import debounce_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int CLK_HZ      = 100000000,
  parameter int SYNC_STAGES = 2,
  parameter int MAX_CODE    = 7
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_PINS-1:0]   rawIn,
  input  logic [NUM_PINS-1:0]   dbEnable,
  input  logic [NUM_PINS*3-1:0] rateCode,
  output logic [NUM_PINS-1:0]   filtOut
);

  localparam int CODE_W   = 3;
  localparam int CNT_W    = MAX_CODE + 1;
  localparam int TICK_DIV = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;

  dbStrobes_t strobes;

  debounce_ctrl #(
    .TICK_DIV (TICK_DIV)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes)
  );

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : gPin
      debounce_datapath #(
        .SYNC_STAGES (SYNC_STAGES),
        .MAX_CODE    (MAX_CODE),
        .CODE_W      (CODE_W),
        .CNT_W       (CNT_W)
      ) uPath (
        .clk      (clk),
        .rstN     (rstN),
        .strobes  (strobes),
        .rawIn    (rawIn[p]),
        .enable   (dbEnable[p]),
        .rateCode (rateCode[p*CODE_W +: CODE_W]),
        .filtOut  (filtOut[p])
      );
    end
  endgenerate

endmodule

// File: tb/tb_pow2_debounce.sv
`timescale 1ns/1ps
module tb_pow2_debounce;

  localparam int NP  = 2;
  localparam int HZ  = 8000;
  localparam int DIV = HZ / 1000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NP-1:0] rawIn = '0;
  logic [NP-1:0] dbEnable = '0;
  logic [NP*3-1:0] rateCode = '0;
  logic [NP-1:0] filtOut;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pow2_debounce #(.NUM_PINS(NP), .CLK_HZ(HZ), .SYNC_STAGES(2), .MAX_CODE(7)) dut (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .dbEnable(dbEnable),
    .rateCode(rateCode), .filtOut(filtOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Count edges until the pin's output changes; must land in [lo, hi].
  task automatic measure(input int pin, input int lo, input int hi, input string req);
    logic old;
    int   k;
    bit   seen;
    old  = filtOut[pin];
    k    = 0;
    seen = 0;
    while (!seen && k < hi + 4) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      if (filtOut[pin] != old) seen = 1;
    end
    checks++;
    if (!seen || k < lo || k > hi) begin
      errors++;
      $display("FAIL %s: output change after %0d edges, expected %0d..%0d", req, k, lo, hi);
    end
  endtask

  task automatic test_reset();
    idle(20);
    check(filtOut == '0, "R1 reset value", int'(filtOut), 0);
  endtask

  task automatic test_bypass();
    dbEnable[0] = 1'b0;
    rawIn[0] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(filtOut[0] == 1'b0, "R2 bypass not early", int'(filtOut[0]), 0);
    @(posedge clk); @(negedge clk);
    check(filtOut[0] == 1'b1, "R2 bypass rise latency", int'(filtOut[0]), 1);
    rawIn[0] = 1'b0;
    measure(0, 3, 3, "R2 bypass fall latency");
  endtask

  task automatic test_settle();
    int codes [4] = '{0, 1, 3, 7};
    dbEnable[0] = 1'b1;
    foreach (codes[i]) begin
      int n;
      n = 1 << codes[i];
      rateCode[2:0] = 3'(codes[i]);
      idle(4);
      rawIn[0] = ~rawIn[0];
      measure(0, 3 + (n - 1) * DIV, 2 + n * DIV, $sformatf("R3 settle code %0d", codes[i]));
      idle(2);
    end
  endtask

  task automatic test_glitch();
    logic v;
    int   bad;
    rateCode[2:0] = 3'd3;
    idle(4);
    v   = filtOut[0];
    bad = 0;
    rawIn[0] = ~v;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (filtOut[0] != v) bad++;
    end
    rawIn[0] = v;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (filtOut[0] != v) bad++;
    end
    check(bad == 0, "R4 short pulse rejected", bad, 0);
  endtask

  task automatic test_restart();
    logic v;
    rateCode[2:0] = 3'd3;
    idle(4);
    v = filtOut[0];
    rawIn[0] = ~v;
    idle(48);
    check(filtOut[0] == v, "R5 still settling before code change", int'(filtOut[0]), int'(v));
    rateCode[2:0] = 3'd2;
    measure(0, 2 + 3 * DIV, 1 + 4 * DIV, "R5 restart on code change");
  endtask

  task automatic test_pins_and_disable();
    logic v0;
    dbEnable[1] = 1'b0;
    dbEnable[0] = 1'b1;
    rateCode[2:0] = 3'd7;
    idle(4);
    v0 = filtOut[0];
    rawIn[0] = ~v0;
    idle(5);
    rawIn[1] = ~filtOut[1];
    measure(1, 3, 3, "R6 pin1 bypass while pin0 settles");
    check(filtOut[0] == v0, "R6 pin0 unaffected by pin1", int'(filtOut[0]), int'(v0));
    rateCode[5:3] = 3'd5;
    dbEnable[1] = 1'b1;
    idle(10);
    check(filtOut[0] == v0, "R6 pin0 unaffected by pin1 config", int'(filtOut[0]), int'(v0));
    dbEnable[0] = 1'b0;
    @(posedge clk); @(negedge clk);
    check(filtOut[0] == ~v0, "R7 disable delivers pending level", int'(filtOut[0]), int'(~v0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    test_reset();
    test_bypass();
    test_settle();
    test_glitch();
    test_restart();
    test_pins_and_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule